// File: doc/BRIEF.md
# Sticky ECC Error Status Register

This block gathers error reports from up to eight ECC decoders into a single 32-bit status word that software reads and clears over a plain register port. Each decoder drives four qualifiers every cycle: a beat-valid strobe, a marker for the first beat of a burst, a single-bit error indication and a double-bit error indication. The block keeps one sticky flag for each decoder and each error class. A flag is raised by hardware and stays raised until software writes a one to it.

Capture is done once per burst and error class. The first beat in a burst that carries a given error class is the only beat that can raise that flag. If software clears the flag in the middle of a burst, later erroneous beats of the same burst do not raise it again. A beat that carries the first-beat marker re-arms capture. The global ECC enable stops new captures but never removes flags that are already set. The number of decoders that are actually built is a parameter. Flag positions for decoders that are not built read as zero.

Top module: `ecc_err_status`

## Requirements
- R1: After a synchronous active-low reset every flag is 0, and a read of the status address returns 32'h0000_0000.
- R2: The status word sits at address `STAT_ADDR` (default 8'h84). The single-bit flag of decoder i is bit i and the double-bit flag of decoder i is bit 8+i. A read at any other address returns 0.
- R3: A valid beat with the first-beat marker set, the ECC enable high and an error of one class sets that decoder's flag for that class, and the flag is visible on the read data one clock after the beat.
- R4: A set flag holds its value with no write. Further errors from the same decoder leave it set.
- R5: A write to the status address clears each flag whose write-data bit is 1 (the cleared value is visible one clock later). Flags whose write-data bit is 0 are unchanged. A write to any other address changes no flag.
- R6: If a capture and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R7: Within a burst, only the first valid beat carrying a given error class can set that class's flag, and it may be any beat of the burst. Once such a capture has happened, later beats of the same burst without the first-beat marker do not set the flag again, even if software has cleared it. The next valid beat with the first-beat marker re-arms capture.
- R8: While the ECC enable is low, no flag is set, and flags already set keep their value.
- R9: Bits 31:16, and the flag bits of decoders numbered `NUM_DEC` or above, always read 0 and ignore errors and writes.
- R10: Error indications on cycles where the beat-valid strobe is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ecc_en | input | 1 | Global ECC enable; low blocks new captures |
| dec_beat_vld | input | 8 | Per-decoder beat-valid strobe |
| dec_first_beat | input | 8 | Per-decoder first-beat-of-burst marker |
| dec_single_err | input | 8 | Per-decoder single-bit error indication |
| dec_double_err | input | 8 | Per-decoder double-bit error indication |
| reg_addr | input | ADDR_W (8) | Register address |
| reg_wr | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data (ones clear flags) |
| reg_rdata | output | 32 | Register read data, combinational from the address |

## Verification
A flag register that drops or picks up a value by mistake shows up on the read data in the very next cycle, because the read path is a pure decode of the flag state. The burst-capture state has no direct view. A wrong value there shows only later: a flag fails to rise on a fresh burst, or comes back after a mid-burst clear, one clock after the beat in question. The bench therefore reads the word after every stimulus cycle, and runs clear-during-burst sequences that make the hidden state visible.

// File: rtl/ecc_stat_pkg.sv
// Package: shared sizes and types for the sticky ECC error status block.
// Assumes at most MAX_DEC decoders and one 32-bit status word.
package ecc_stat_pkg;

    localparam int MAX_DEC = 8;
    localparam int REG_W   = 32;
    localparam int FLAG_W  = 2 * MAX_DEC;
    localparam int SBE_LSB = 0;
    localparam int DBE_LSB = MAX_DEC;

    // Error class index; also selects the flag half in the status word.
    typedef enum logic [0:0] {
        ERR_SINGLE = 1'b0,
        ERR_DOUBLE = 1'b1
    } err_kind_e;

    // One decoder's per-cycle report.
    typedef struct packed {
        logic vld;
        logic first;
        logic sbe;
        logic dbe;
    } dec_rpt_t;

endpackage

// File: rtl/ecc_burst_gate.sv
// Module: per-decoder capture gate.
// For each error class it produces a one-cycle capture pulse on the first
// valid beat of a burst that carries that class. A beat marked as first
// re-arms the gate. Assumes the decoder asserts the first-beat marker only
// together with its beat-valid strobe.
module ecc_burst_gate
    import ecc_stat_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en_i,
    input  dec_rpt_t rpt_i,
    output logic [1:0] cap_o
);

    logic [1:0] err_k;
    logic       new_burst;

    // Route the two error indications by class index.
    always_comb begin
        err_k             = '0;
        err_k[ERR_SINGLE] = rpt_i.sbe;
        err_k[ERR_DOUBLE] = rpt_i.dbe;
    end

    assign new_burst = rpt_i.vld & rpt_i.first;

    for (genvar k = 0; k < 2; k++) begin : g_kind
        logic hit;
        logic seen_q;

        assign hit      = rpt_i.vld & err_k[k] & en_i;
        assign cap_o[k] = hit & (rpt_i.first | ~seen_q);

        // Remember whether this burst already produced a capture of class k.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seen_q <= 1'b0;
            end else if (new_burst) begin
                seen_q <= hit;
            end else if (cap_o[k]) begin
                seen_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ecc_flag_cell.sv
// Module: one sticky flag with write-one-to-clear.
// A set request has priority over a clear in the same cycle, so that no
// error report is lost.
module ecc_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    // Hold, set or clear the flag; the set request wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end

endmodule

// File: rtl/ecc_reg_port.sv
// Module: address decode for the status word.
// Builds per-flag clear requests from writes and returns the read data.
// Purely combinational. Assumes a single status address.
module ecc_reg_port
    import ecc_stat_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h84
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [FLAG_W-1:0] clr_o,
    output logic [REG_W-1:0]  rdata_o
);

    localparam int RSV_W = REG_W - FLAG_W;

    logic sel;
    logic unused_wdata_hi;

    assign sel             = (addr_i == STAT_ADDR);
    assign unused_wdata_hi = ^wdata_i[REG_W-1:FLAG_W];

    // Turn a write of ones at the status address into clear requests.
    always_comb begin
        clr_o = '0;
        if (wr_i && sel) begin
            clr_o = wdata_i[FLAG_W-1:0];
        end
    end

    // Return the flag word at the status address, zero elsewhere.
    always_comb begin
        rdata_o = '0;
        if (sel) begin
            rdata_o = {{RSV_W{1'b0}}, flags_i};
        end
    end

endmodule

// File: rtl/ecc_err_status.sv
// Module: top of the sticky ECC error status register.
// Collects single- and double-bit error reports from NUM_DEC decoders,
// one gate per decoder and one flag cell per decoder and class. Positions
// of decoders that are not built are tied to zero.
// Assumes synchronous active-low reset and NUM_DEC in 1..MAX_DEC.
module ecc_err_status
    import ecc_stat_pkg::*;
#(
    parameter int                NUM_DEC   = 8,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h84
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ecc_en,
    input  logic [MAX_DEC-1:0] dec_beat_vld,
    input  logic [MAX_DEC-1:0] dec_first_beat,
    input  logic [MAX_DEC-1:0] dec_single_err,
    input  logic [MAX_DEC-1:0] dec_double_err,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata
);

    logic [FLAG_W-1:0] flag_vec;
    logic [FLAG_W-1:0] clr_vec;

    for (genvar d = 0; d < MAX_DEC; d++) begin : g_dec
        if (d < NUM_DEC) begin : g_on
            dec_rpt_t   rpt;
            logic [1:0] cap;

            assign rpt = '{vld:   dec_beat_vld[d],
                           first: dec_first_beat[d],
                           sbe:   dec_single_err[d],
                           dbe:   dec_double_err[d]};

            ecc_burst_gate u_gate (
                .clk   (clk),
                .rst_n (rst_n),
                .en_i  (ecc_en),
                .rpt_i (rpt),
                .cap_o (cap)
            );

            ecc_flag_cell u_sbe (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (cap[ERR_SINGLE]),
                .clr_i  (clr_vec[SBE_LSB + d]),
                .flag_o (flag_vec[SBE_LSB + d])
            );

            ecc_flag_cell u_dbe (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (cap[ERR_DOUBLE]),
                .clr_i  (clr_vec[DBE_LSB + d]),
                .flag_o (flag_vec[DBE_LSB + d])
            );
        end else begin : g_off
            logic unused_dec;

            assign unused_dec = ^{dec_beat_vld[d], dec_first_beat[d],
                                  dec_single_err[d], dec_double_err[d],
                                  clr_vec[SBE_LSB + d], clr_vec[DBE_LSB + d]};
            assign flag_vec[SBE_LSB + d] = 1'b0;
            assign flag_vec[DBE_LSB + d] = 1'b0;
        end
    end

    ecc_reg_port #(
        .ADDR_W    (ADDR_W),
        .STAT_ADDR (STAT_ADDR)
    ) u_port (
        .addr_i  (reg_addr),
        .wr_i    (reg_wr),
        .wdata_i (reg_wdata),
        .flags_i (flag_vec),
        .clr_o   (clr_vec),
        .rdata_o (reg_rdata)
    );

endmodule

// File: rtl/ecc_err_status_chk.sv
// Module: assertion checker for ecc_err_status, attached by bind.
// Relates the port activity to the flag vector over time.
module ecc_err_status_chk
    import ecc_stat_pkg::*;
#(
    parameter int                NUM_DEC   = 8,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h84
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ecc_en,
    input logic [MAX_DEC-1:0] vld,
    input logic [MAX_DEC-1:0] first,
    input logic [MAX_DEC-1:0] sbe,
    input logic [MAX_DEC-1:0] dbe,
    input logic [ADDR_W-1:0]  addr,
    input logic               wr,
    input logic [REG_W-1:0]   wdata,
    input logic [REG_W-1:0]   rdata,
    input logic [FLAG_W-1:0]  flags
);

    localparam logic [MAX_DEC-1:0] IMPL = MAX_DEC'((1 << NUM_DEC) - 1);

    logic [FLAG_W-1:0] clr_req;

    assign clr_req = (wr && (addr == STAT_ADDR)) ? wdata[FLAG_W-1:0] : '0;

    // R1: the first cycle out of reset sees no flag.
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flags == '0));

    // R2: other addresses read zero.
    assert_other_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != STAT_ADDR) |-> (rdata == '0));

    // R9: reserved bits and absent decoders stay zero.
    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[REG_W-1:FLAG_W] == '0) && ((flags & ~{IMPL, IMPL}) == '0));

    // R4: a set flag only falls after a clearing write.
    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(flags) & ~$past(clr_req)) & ~flags) == '0));

    // R3 and R6: a first-beat single error always sets, even against a clear.
    assert_first_sbe_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(vld & first & sbe) & {MAX_DEC{$past(ecc_en)}} & IMPL
          & ~flags[MAX_DEC-1:0]) == '0));

    // R3 and R6: same for double errors.
    assert_first_dbe_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(vld & first & dbe) & {MAX_DEC{$past(ecc_en)}} & IMPL
          & ~flags[FLAG_W-1:MAX_DEC]) == '0));

    // R8: no new flag while the enable was low.
    assert_disabled_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ecc_en) |-> ((flags & ~$past(flags)) == '0));

    // R10: no new flag without any valid beat.
    assert_invalid_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(vld) == '0) |-> ((flags & ~$past(flags)) == '0));

endmodule

bind ecc_err_status ecc_err_status_chk #(
    .NUM_DEC   (NUM_DEC),
    .ADDR_W    (ADDR_W),
    .STAT_ADDR (STAT_ADDR)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ecc_en (ecc_en),
    .vld    (dec_beat_vld),
    .first  (dec_first_beat),
    .sbe    (dec_single_err),
    .dbe    (dec_double_err),
    .addr   (reg_addr),
    .wr     (reg_wr),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .flags  (flag_vec)
);

// File: tb/tb_ecc_err_status.sv
`timescale 1ns/1ps
// Bench: six decoders built out of eight positions, swept per decoder and
// class, with a per-burst reference model derived from the requirements.
module tb_ecc_err_status;

    localparam int         NDEC = 6;
    localparam logic [7:0] STAT = 8'h84;
    localparam logic [7:0] IMPL = 8'h3F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ecc_en = 1'b1;
    logic [7:0]  vld = '0, fst = '0, sbe = '0, dbe = '0;
    logic [7:0]  reg_addr = STAT;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int          nchk = 0;
    int          nfail = 0;
    logic [15:0] exp_flags = '0;
    logic [7:0]  rep_s = '0, rep_d = '0;

    always #5 clk = ~clk;

    ecc_err_status #(.NUM_DEC(NDEC), .ADDR_W(8), .STAT_ADDR(STAT)) dut (
        .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en),
        .dec_beat_vld(vld), .dec_first_beat(fst),
        .dec_single_err(sbe), .dec_double_err(dbe),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    // One clock of stimulus; the model computes the next flag state.
    task automatic cyc(input logic [7:0] v, input logic [7:0] f,
                       input logic [7:0] s, input logic [7:0] d,
                       input logic en, input logic w,
                       input logic [7:0] a, input logic [31:0] wd);
        logic [15:0] nf;
        logic [7:0]  ns, nd;
        vld = v; fst = f; sbe = s; dbe = d; ecc_en = en;
        reg_wr = w; reg_addr = a; reg_wdata = wd;
        nf = exp_flags; ns = rep_s; nd = rep_d;
        for (int i = 0; i < NDEC; i++) begin
            for (int k = 0; k < 2; k++) begin
                logic err, hit, cap, rp, clr;
                err = (k == 1) ? d[i] : s[i];
                rp  = (k == 1) ? rep_d[i] : rep_s[i];
                hit = v[i] & err & en;
                cap = hit & (f[i] | ~rp);
                if (v[i] & f[i]) rp = hit;
                else if (cap)    rp = 1'b1;
                clr = w && (a == STAT) && wd[k*8+i];
                if (cap)      nf[k*8+i] = 1'b1;
                else if (clr) nf[k*8+i] = 1'b0;
                if (k == 1) nd[i] = rp; else ns[i] = rp;
            end
        end
        @(posedge clk);
        #1;
        exp_flags = nf; rep_s = ns; rep_d = nd;
    endtask

    task automatic idle();
        cyc(8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, STAT, 32'h0);
    endtask

    task automatic clr_all();
        cyc(8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1, STAT, 32'hFFFF_FFFF);
    endtask

    // Compare the read word with a given value (inputs quiet, status address).
    task automatic chk_val(input string tag, input logic [31:0] expv);
        reg_wr = 1'b0; vld = '0; reg_addr = STAT;
        #1;
        nchk++;
        if (reg_rdata !== expv) begin
            nfail++;
            $display("FAIL %s rdata=%h expected=%h", tag, reg_rdata, expv);
        end
    endtask

    task automatic chk(input string tag);
        chk_val(tag, {16'h0, exp_flags});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk_val("R1 in reset", 32'h0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk_val("R1 after reset", 32'h0);

        // R3 R2 R9 R5: sweep every position and class.
        for (int dd = 0; dd < 8; dd++) begin
            for (int k = 0; k < 2; k++) begin
                logic [7:0]  m;
                logic [31:0] lit;
                m = 8'(1 << dd);
                cyc(m, m, (k == 0) ? m : 8'h0, (k == 1) ? m : 8'h0,
                    1'b1, 1'b0, STAT, 32'h0);
                lit = (dd < NDEC) ? (32'h1 << (k*8 + dd)) : 32'h0;
                chk_val("R3 R2 R9 sweep set", lit);
                cyc(8'h0, 8'h0, 8'h0, 8'h0, 1'b1, 1'b1, STAT, 32'h1 << (k*8 + dd));
                chk_val("R5 sweep clear", 32'h0);
            end
        end

        // R4: sticky with idles and repeated errors.
        cyc(8'h02, 8'h02, 8'h02, 8'h00, 1'b1, 1'b0, STAT, 32'h0);
        repeat (3) idle();
        chk_val("R4 holds idle", 32'h0000_0002);
        cyc(8'h02, 8'h02, 8'h02, 8'h00, 1'b1, 1'b0, STAT, 32'h0);
        cyc(8'h02, 8'h00, 8'h02, 8'h00, 1'b1, 1'b0, STAT, 32'h0);
        chk_val("R4 repeated error", 32'h0000_0002);

        // R5: zero write and write elsewhere leave flags.
        cyc(8'h20, 8'h20, 8'h00, 8'h20, 1'b1, 1'b0, STAT, 32'h0);
        cyc(8'h0, 8'h0, 8'h0, 8'h0, 1'b1, 1'b1, STAT, 32'h0);
        chk_val("R5 write zero", 32'h0000_2002);
        cyc(8'h0, 8'h0, 8'h0, 8'h0, 1'b1, 1'b1, 8'h10, 32'hFFFF_FFFF);
        chk_val("R5 other address write", 32'h0000_2002);
        reg_addr = 8'h10; #1;
        nchk++;
        if (reg_rdata !== 32'h0) begin
            nfail++;
            $display("FAIL R2 other address read rdata=%h expected=%h", reg_rdata, 32'h0);
        end
        cyc(8'h0, 8'h0, 8'h0, 8'h0, 1'b1, 1'b1, STAT, 32'h0000_2000);
        chk_val("R5 partial clear", 32'h0000_0002);

        // R6: set beats clear in the same cycle.
        cyc(8'h06, 8'h06, 8'h06, 8'h00, 1'b1, 1'b1, STAT, 32'h0000_0006);
        chk_val("R6 set wins", 32'h0000_0006);
        clr_all();
        chk_val("R5 clear all", 32'h0);

        // R7: capture on a later beat, one capture per burst, re-arm.
        cyc(8'h10, 8'h10, 8'h00, 8'h00, 1'b1, 1'b0, STAT, 32'h0);
        chk_val("R7 clean first beat", 32'h0);
        cyc(8'h10, 8'h00, 8'h00, 8'h10, 1'b1, 1'b0, STAT, 32'h0);
        chk_val("R7 later beat captures", 32'h0000_1000);
        cyc(8'h10, 8'h00, 8'h00, 8'h10, 1'b1, 1'b1, STAT, 32'h0000_1000);
        chk_val("R7 clear mid burst", 32'h0);
        cyc(8'h10, 8'h00, 8'h10, 8'h10, 1'b1, 1'b0, STAT, 32'h0);
        chk_val("R7 no recapture in burst", 32'h0000_0010);
        cyc(8'h10, 8'h10, 8'h00, 8'h00, 1'b1, 1'b0, STAT, 32'h0);
        cyc(8'h10, 8'h00, 8'h00, 8'h10, 1'b1, 1'b0, STAT, 32'h0);
        chk_val("R7 re-armed", 32'h0000_1010);
        chk("R7 model");
        clr_all();

        // R8: enable low blocks capture and keeps flags.
        cyc(8'h01, 8'h01, 8'h01, 8'h00, 1'b1, 1'b0, STAT, 32'h0);
        cyc(8'h3F, 8'h3F, 8'h3F, 8'h3F, 1'b0, 1'b0, STAT, 32'h0);
        cyc(8'h3F, 8'h00, 8'h3F, 8'h3F, 1'b0, 1'b0, STAT, 32'h0);
        chk_val("R8 enable off", 32'h0000_0001);

        // R10: errors without valid.
        cyc(8'h00, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b0, STAT, 32'h0);
        chk_val("R10 invalid beat", 32'h0000_0001);
        clr_all();

        // R9: reserved writes and absent decoders.
        cyc(8'hC0, 8'hC0, 8'hC0, 8'hC0, 1'b1, 1'b1, STAT, 32'hFFFF_0000);
        chk_val("R9 reserved", 32'h0);

        // R2 R3: exhaustive class patterns across all positions.
        for (int m = 0; m < 256; m++) begin
            logic [7:0] s8;
            s8 = 8'(m);
            cyc(8'hFF, 8'hFF, s8, ~s8, 1'b1, 1'b0, STAT, 32'h0);
            chk_val("R2 R3 pattern", {16'h0, (~s8) & IMPL, s8 & IMPL});
            clr_all();
            chk("R5 pattern clear");
        end

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #2000000;
        nfail++;
        $display("FAIL watchdog expired rdata=%h expected=finish", reg_rdata);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule